// File: doc/BRIEF.md
# Write-Enable Latch and Erase Launch Gate

This block holds the permission and status state that sits behind the modify commands of a serial flash. It keeps three status flags: a write-enable latch, a busy flag and an erase/program error flag. A front end decodes each transaction. When chip select is released, the front end hands this block one pulse. The pulse carries the opcode and the number of serial bits that were clocked in while chip select was low.

From those inputs the block decides what happens. It can set the latch, clear it, or launch an erase, or it can leave everything unchanged. An erase is modelled as a self-timed operation that lasts a parameterised number of clock cycles. During that time the busy flag stays high and the status can be polled. A test input can mark the erase as failed, and the error flag then reports the failure when the erase ends. The array protection state is an input. The erase scope (page, 4 KB, 32 KB or whole array) is sent on a one-cycle launch strobe to the array sequencer downstream.

Top module: `wel_erase_gate`

## Requirements
- R1: After reset, `status_o` is all zero and `erase_go_o` is low. The status layout is: bit 0 busy, bit 1 write-enable latch, bit 5 error, and all other bits are always 0.
- R2: Opcode 06h with a bit count of at least 8 that is a multiple of 8 sets the latch on the next cycle. Bytes that follow the opcode do not change this result.
- R3: Opcode 06h with a bit count below 8, or a bit count that is not a multiple of 8, leaves the latch unchanged.
- R4: Opcodes 81h (page, scope 0), 20h (4 KB, scope 1) and 52h (32 KB, scope 2) launch an erase when the latch is set and the bit count is a multiple of 8 that is at least 32. On the next cycle `erase_go_o` pulses for one cycle with `erase_scope_o` set to the scope code, busy rises and the latch clears.
- R5: An erase opcode (81h, 20h, 52h or 60h) with an aligned bit count has no effect when the latch is clear. An 81h, 20h or 52h command with an aligned bit count below 32 also has no effect.
- R6: An erase opcode whose bit count is 8 or more but not a multiple of 8 launches nothing and clears the latch.
- R7: Opcode 60h with a latch that is set and an aligned bit count of at least 8 does one of two things. If `protect_i` is low, it launches a whole-array erase (scope 3). If `protect_i` is high, it launches nothing and clears the latch.
- R8: Busy stays high for exactly `ERASE_CYCLES` cycles after the launch and then clears.
- R9: When an erase ends, the error bit takes the value that `fail_inject_i` had at launch. At all other times the error bit holds its value.
- R10: While busy, every command is ignored. Status read (05h) and unrecognised opcodes never change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle pulse when chip select is released |
| cmd_opcode_i | input | 8 | Opcode of the ended transaction |
| cmd_bits_i | input | CNT_W | Serial bits clocked while chip select was low |
| protect_i | input | 1 | Array is in the protected state |
| fail_inject_i | input | 1 | Mark the erase launched now as failed |
| status_o | output | 8 | Status register |
| erase_go_o | output | 1 | One-cycle erase launch strobe |
| erase_scope_o | output | 2 | Scope of the launched erase |

## Verification
The bench builds the block with `ERASE_CYCLES` set to 6 and `CNT_W` set to 10. The erase window then closes within a few cycles, so the stimulus reaches both the end-of-busy edge and the error-bit update many times. Random bit counts between 0 and 48 cover all cases of the bit-count check: no complete opcode, partial bytes, aligned counts that are too short for an address, and trailing data after a complete address.

// File: rtl/wel_gate_pkg.sv
package wel_gate_pkg;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_ER_PAGE = 8'h81;
  localparam logic [7:0] OP_ER_4K   = 8'h20;
  localparam logic [7:0] OP_ER_32K  = 8'h52;
  localparam logic [7:0] OP_ER_CHIP = 8'h60;

  typedef enum logic [1:0] {
    SCOPE_PAGE = 2'd0,
    SCOPE_4K   = 2'd1,
    SCOPE_32K  = 2'd2,
    SCOPE_CHIP = 2'd3
  } scope_e;

  typedef struct packed {
    logic   set_wel;
    logic   clr_wel;
    logic   launch;
    scope_e scope;
  } verdict_t;
endpackage

// File: rtl/cmd_judge.sv
module cmd_judge
  import wel_gate_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ADDR_BYTES = 3
) (
  input  logic             valid_i,
  input  logic [7:0]       opcode_i,
  input  logic [CNT_W-1:0] bits_i,
  input  logic             wel_i,
  input  logic             busy_i,
  input  logic             protect_i,
  output verdict_t         verdict_o
);
  localparam int ERASE_BITS = 8 * (1 + ADDR_BYTES);

  logic has_op, aligned, full_addr;

  always_comb begin
    has_op    = bits_i >= CNT_W'(8);
    aligned   = bits_i[2:0] == 3'b000;
    full_addr = bits_i >= CNT_W'(ERASE_BITS);
    verdict_o = '0;
    if (valid_i && !busy_i && has_op) begin
      case (opcode_i)
        OP_WREN: verdict_o.set_wel = aligned;
        OP_ER_PAGE, OP_ER_4K, OP_ER_32K: begin
          if (!aligned) verdict_o.clr_wel = 1'b1;
          else if (wel_i && full_addr) begin
            verdict_o.launch = 1'b1;
            verdict_o.scope  = (opcode_i == OP_ER_PAGE) ? SCOPE_PAGE :
                               (opcode_i == OP_ER_4K)   ? SCOPE_4K : SCOPE_32K;
          end
        end
        OP_ER_CHIP: begin
          if (!aligned) verdict_o.clr_wel = 1'b1;
          else if (wel_i) begin
            if (protect_i) verdict_o.clr_wel = 1'b1;
            else begin
              verdict_o.launch = 1'b1;
              verdict_o.scope  = SCOPE_CHIP;
            end
          end
        end
        default: ;  // status read and unknown opcodes: no action
      endcase
    end
  end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int ERASE_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CYC_W = $clog2(ERASE_CYCLES + 1);

  logic [CYC_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CYC_W'(ERASE_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // no relaunch while an erase runs
  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  // busy persists until the terminal count
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q);
  assert_busy_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/wel_erase_gate.sv
module wel_erase_gate
  import wel_gate_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int ADDR_BYTES   = 3,
  parameter int ERASE_CYCLES = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_opcode_i,
  input  logic [CNT_W-1:0] cmd_bits_i,
  input  logic             protect_i,
  input  logic             fail_inject_i,
  output logic [7:0]       status_o,
  output logic             erase_go_o,
  output logic [1:0]       erase_scope_o
);
  verdict_t verdict;
  logic     wel_q, err_q, arm_q, go_q, busy, done;
  scope_e   scope_q;

  cmd_judge #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) u_judge (
    .valid_i   (cmd_valid_i),
    .opcode_i  (cmd_opcode_i),
    .bits_i    (cmd_bits_i),
    .wel_i     (wel_q),
    .busy_i    (busy),
    .protect_i (protect_i),
    .verdict_o (verdict)
  );

  erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (verdict.launch),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q   <= 1'b0;
      err_q   <= 1'b0;
      arm_q   <= 1'b0;
      go_q    <= 1'b0;
      scope_q <= SCOPE_PAGE;
    end else begin
      go_q <= verdict.launch;
      if (verdict.launch) begin
        scope_q <= verdict.scope;
        arm_q   <= fail_inject_i;
      end
      if (verdict.set_wel)                        wel_q <= 1'b1;
      else if (verdict.clr_wel || verdict.launch) wel_q <= 1'b0;
      if (done) err_q <= arm_q;
    end
  end

  assign status_o      = {2'b00, err_q, 3'b000, wel_q, busy};
  assign erase_go_o    = go_q;
  assign erase_scope_o = scope_q;

  assert_launch_effects_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict.launch |=> (go_q && busy && !wel_q));
  assert_go_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |=> !go_q);
  assert_launch_needs_wel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict.launch |-> wel_q);
  assert_misaligned_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy && cmd_bits_i >= CNT_W'(8) && cmd_bits_i[2:0] != 3'b000 &&
     (cmd_opcode_i == OP_ER_PAGE || cmd_opcode_i == OP_ER_4K ||
      cmd_opcode_i == OP_ER_32K  || cmd_opcode_i == OP_ER_CHIP)) |=> (!wel_q && !go_q));
  assert_protect_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_opcode_i == OP_ER_CHIP && protect_i) |=> !go_q);
  assert_busy_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy && !done) |=> ($stable(wel_q) && $stable(err_q)));
  assert_err_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(err_q));
endmodule

// File: tb/wel_erase_gate_test.sv
`timescale 1ns/1ps
module wel_erase_gate_test;
  localparam int CNT_W = 10;
  localparam int NCYC  = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [7:0]       cmd_opcode_i = 8'h00;
  logic [CNT_W-1:0] cmd_bits_i = '0;
  logic             protect_i = 1'b0;
  logic             fail_inject_i = 1'b0;
  logic [7:0]       status_o;
  logic             erase_go_o;
  logic [1:0]       erase_scope_o;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit m_wel, m_busy, m_err, m_arm;
  int m_rem;
  bit e_go;
  bit [1:0] e_scope;

  always #2.5 clk = ~clk;

  wel_erase_gate #(.CNT_W(CNT_W), .ADDR_BYTES(3), .ERASE_CYCLES(NCYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_opcode_i(cmd_opcode_i),
    .cmd_bits_i(cmd_bits_i), .protect_i(protect_i), .fail_inject_i(fail_inject_i),
    .status_o(status_o), .erase_go_o(erase_go_o), .erase_scope_o(erase_scope_o)
  );

  function automatic bit [7:0] exp_status(bit busy, bit wel, bit err);
    return {2'b00, err, 3'b000, wel, busy};
  endfunction

  function automatic bit is_erase(bit [7:0] op);
    return op == 8'h81 || op == 8'h20 || op == 8'h52 || op == 8'h60;
  endfunction

  function automatic bit [1:0] scope_of(bit [7:0] op);
    case (op)
      8'h81:   return 2'd0;
      8'h20:   return 2'd1;
      8'h52:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic string tag_of(bit v, bit busy, bit [7:0] op);
    if (!v)           return "R8";
    if (busy)         return "R10";
    if (op == 8'h06)  return "R2";
    if (op == 8'h60)  return "R7";
    if (is_erase(op)) return "R4";
    return "R10";
  endfunction

  // apply one cycle of stimulus, advance the reference, compare after the edge
  task automatic step(bit v, bit [7:0] op, int bits, bit prot, bit fail, string tag);
    bit pre_busy;
    bit [7:0] exp;
    cmd_valid_i   = v;
    cmd_opcode_i  = op;
    cmd_bits_i    = CNT_W'(bits);
    protect_i     = prot;
    fail_inject_i = fail;
    pre_busy = m_busy;
    e_go = 1'b0;
    if (pre_busy) begin
      m_rem--;
      if (m_rem == 0) begin m_busy = 1'b0; m_err = m_arm; end
    end
    if (v && !pre_busy && bits >= 8) begin
      bit aligned = (bits % 8) == 0;
      if (op == 8'h06) begin
        if (aligned) m_wel = 1'b1;
      end else if (is_erase(op)) begin
        if (!aligned) m_wel = 1'b0;
        else if (m_wel) begin
          if (op == 8'h60 && prot) m_wel = 1'b0;
          else if (op == 8'h60 || bits >= 32) begin
            m_wel = 1'b0; m_busy = 1'b1; m_rem = NCYC; m_arm = fail;
            e_go = 1'b1; e_scope = scope_of(op);
          end
        end
      end
    end
    @(negedge clk);
    cmd_valid_i = 1'b0;
    exp = exp_status(m_busy, m_wel, m_err);
    checks++;
    if (status_o !== exp || erase_go_o !== e_go || (e_go && erase_scope_o !== e_scope)) begin
      fails++;
      $display("FAIL %s: op=%h bits=%0d status=%h go=%b scope=%0d expected status=%h go=%b scope=%0d",
               tag, op, bits, status_o, erase_go_o, erase_scope_o, exp, e_go, e_scope);
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (status_o !== 8'h00 || erase_go_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: status=%h go=%b expected status=00 go=0", status_o, erase_go_o);
    end

    step(1, 8'h06, 8,  0, 0, "R2");   // set latch
    step(1, 8'h05, 8,  0, 0, "R10");  // status read no effect
    step(1, 8'hAB, 16, 0, 0, "R10");  // unknown opcode
    step(1, 8'h81, 24, 0, 0, "R5");   // short address
    step(1, 8'h81, 32, 0, 0, "R4");   // page erase launches
    step(1, 8'h06, 8,  0, 0, "R10");  // ignored while busy
    idle(NCYC, "R8");
    step(1, 8'h06, 7,  0, 0, "R3");
    step(1, 8'h06, 13, 0, 0, "R3");
    step(1, 8'h06, 4,  0, 0, "R3");
    step(1, 8'h06, 16, 0, 0, "R2");   // trailing byte ignored
    step(1, 8'h20, 33, 0, 0, "R6");   // misaligned clears latch
    step(1, 8'h06, 8,  0, 0, "R2");
    step(1, 8'h52, 40, 0, 1, "R4");   // 32K erase, forced failure
    idle(NCYC, "R9");
    step(1, 8'h06, 8,  0, 0, "R2");
    step(1, 8'h20, 32, 0, 0, "R4");
    idle(NCYC, "R9");                 // error clears after good erase
    step(1, 8'h60, 8,  0, 0, "R5");   // no latch
    step(1, 8'h06, 8,  0, 0, "R2");
    step(1, 8'h60, 8,  1, 0, "R7");   // protected: latch cleared
    step(1, 8'h06, 8,  0, 0, "R2");
    step(1, 8'h60, 8,  0, 0, "R7");   // chip erase
    idle(NCYC, "R8");
    step(1, 8'h20, 32, 0, 0, "R5");

    for (int i = 0; i < 600; i++) begin
      bit [7:0] ops [8] = '{8'h06, 8'h06, 8'h81, 8'h20, 8'h52, 8'h60, 8'h05, 8'h3C};
      bit v = ($urandom % 4) != 0;
      bit [7:0] op = ops[$urandom % 8];
      int bits = (($urandom % 3) == 0) ? int'($urandom % 49) : 8 * int'($urandom % 7);
      step(v, op, bits, ($urandom % 3) == 0, ($urandom % 2) == 1, tag_of(v, m_busy, op));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule